// File: doc/BRIEF.md
# Narrow-Bus Unaligned Access Sequencer

This block sits between a CPU-side port that asks for 1, 2 or 3 bytes at any byte offset inside a 32-bit longword and a 16-bit peripheral bus. The bus offers three cycle types: word read, word write and byte write. Each request is turned into the shortest fixed sequence of those cycles. A request never becomes a read-modify-write, and it never produces a spare bus cycle. Both rules matter because peripheral reads can change device state, and because a merged word write does not behave like a byte write.

The CPU presents the address, the length, right-justified write data and the direction together with a one-cycle `req_i`. The block latches the request, then issues bus cycles one at a time. Each cycle is held until `bus_ready_i` is sampled high. `done_o` pulses once the request is finished. Read data comes back in its longword lane position and is not shifted down to bit 0.

Top module: `narrow_access_seq`

## Requirements
- R1: After reset, `done_o` and `bus_valid_o` are low and `rdata_o` is zero.
- R2: A read issues one word read (kind 0) at the address with bit 0 cleared when length plus address bit 0 is at most 2. Otherwise it issues a second word read at that address plus 2 and no other cycles.
- R3: For a single read, the returned halfword lands in `rdata_o[31:16]` when address bit 1 is set, and in `rdata_o[15:0]` otherwise. The other half reads as zero.
- R4: For a two-read access, the first halfword lands in `rdata_o[15:0]` and the second in `rdata_o[31:16]`.
- R5: A 1-byte write at any offset is a single byte write (kind 2) at the request address. It carries `wdata_i[7:0]` in `bus_wdata_o[7:0]`, with `bus_wdata_o[15:8]` zero, as for every byte write.
- R6: A 2-byte write at an even address is one word write (kind 1) of `wdata_i[15:0]`. At an odd address it is a byte write of bits 7:0 at the address, then a byte write of bits 15:8 at address+1.
- R7: A 3-byte write at an odd address is a byte write of bits 7:0, then a word write of bits 23:8 at address+1. At an even address it is a word write of bits 15:0, then a byte write of bits 23:16 at address+2.
- R8: Only one bus cycle is outstanding at a time. `bus_valid_o`, the address, the kind and the data hold steady until `bus_ready_i` is sampled. `done_o` is high for exactly the one cycle after the edge that completes the last bus cycle.
- R9: A length of 0 or 4 to 7, or an offset plus length above 4, issues no bus cycle. Such a request reports `done_o` in the second cycle after acceptance, with `rdata_o` zero.
- R10: `req_i` seen while a request is in progress is ignored and adds no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, taken when idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Byte address |
| len_i | input | 3 | Length in bytes (1 to 3 valid) |
| wdata_i | input | 32 | Right-justified write data |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Read data in lane position |
| bus_valid_o | output | 1 | Bus cycle pending |
| bus_kind_o | output | 2 | 0 word read, 1 word write, 2 byte write |
| bus_addr_o | output | AW | Bus byte address |
| bus_wdata_o | output | 16 | Bus write data (byte in bits 7:0) |
| bus_ready_i | input | 1 | Bus cycle accepted this edge |
| bus_rdata_i | input | 16 | Bus read halfword |

## Verification
The hardest case to reach from the ports is a new `req_i` that arrives during a two-cycle sequence while the bus is stalling. The block has to ignore it without adding a cycle or corrupting the latched operands. The bench holds `req_i` high, with changed address, length and direction, for the whole span of some requests. It does this while random wait states stretch both cycles, and it then compares the logged bus cycles against the list computed for the original request. Every legal offset and length pair is also driven in both directions, so that both cycle orderings of the tribyte writes are seen.

// File: rtl/nas_pkg.sv
package nas_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    BUS_RD_WORD = 2'd0,
    BUS_WR_WORD = 2'd1,
    BUS_WR_BYTE = 2'd2
  } bus_kind_e;

  typedef struct packed {
    bus_kind_e         kind;
    logic [1:0]        lane;
    logic [HALF_W-1:0] data;
  } bus_step_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_FIN   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/nas_planner.sv
module nas_planner
  import nas_pkg::*;
(
  input  logic [1:0]        off_i,
  input  logic [2:0]        len_i,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              legal_o,
  output logic              two_o,
  output bus_step_t         s0_o,
  output bus_step_t         s1_o
);
  logic [2:0] span;
  assign span    = {1'b0, off_i} + len_i;
  assign legal_o = (len_i != 3'd0) && (len_i <= 3'd3) && (span <= 3'd4);

  always_comb begin
    two_o = 1'b0;
    s0_o  = '{kind: BUS_RD_WORD, lane: {off_i[1], 1'b0}, data: '0};
    s1_o  = '{kind: BUS_RD_WORD, lane: 2'd2, data: '0};
    if (!we_i) begin
      two_o = ({1'b0, len_i} + {3'b0, off_i[0]}) > 4'd2;
    end else begin
      unique case (len_i)
        3'd2: begin
          if (off_i[0]) begin
            two_o = 1'b1;
            s0_o  = '{kind: BUS_WR_BYTE, lane: off_i, data: {8'h00, wdata_i[7:0]}};
            s1_o  = '{kind: BUS_WR_BYTE, lane: off_i + 2'd1, data: {8'h00, wdata_i[15:8]}};
          end else begin
            s0_o  = '{kind: BUS_WR_WORD, lane: off_i, data: wdata_i[15:0]};
          end
        end
        3'd3: begin
          two_o = 1'b1;
          if (off_i[0]) begin
            s0_o = '{kind: BUS_WR_BYTE, lane: off_i, data: {8'h00, wdata_i[7:0]}};
            s1_o = '{kind: BUS_WR_WORD, lane: off_i + 2'd1, data: wdata_i[23:8]};
          end else begin
            s0_o = '{kind: BUS_WR_WORD, lane: off_i, data: wdata_i[15:0]};
            s1_o = '{kind: BUS_WR_BYTE, lane: off_i + 2'd2, data: {8'h00, wdata_i[23:16]}};
          end
        end
        default: begin
          s0_o = '{kind: BUS_WR_BYTE, lane: off_i, data: {8'h00, wdata_i[7:0]}};
        end
      endcase
    end
  end
endmodule

// File: rtl/nas_read_pack.sv
module nas_read_pack
  import nas_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              cap_i,
  input  logic              second_i,
  input  logic              split_i,
  input  logic              hi_i,
  input  logic [HALF_W-1:0] half_i,
  output logic [WORD_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
    end else if (clear_i) begin
      data_o <= '0;
    end else if (cap_i) begin
      if (second_i || (!split_i && hi_i)) data_o[WORD_W-1:HALF_W] <= half_i;
      else                                data_o[HALF_W-1:0]      <= half_i;
    end
  end
endmodule

// File: rtl/narrow_access_seq.sv
module narrow_access_seq
  import nas_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [2:0]        len_i,
  input  logic [31:0]       wdata_i,
  output logic              done_o,
  output logic [31:0]       rdata_o,
  output logic              bus_valid_o,
  output logic [1:0]        bus_kind_o,
  output logic [AW-1:0]     bus_addr_o,
  output logic [15:0]       bus_wdata_o,
  input  logic              bus_ready_i,
  input  logic [15:0]       bus_rdata_i
);
  seq_state_e        state_q;
  logic              step_q, we_q;
  logic [AW-1:0]     addr_q;
  logic [2:0]        len_q;
  logic [WORD_W-1:0] wdata_q;
  logic              legal, two, hs, accept;
  bus_step_t         s0, s1, cur;

  nas_planner i_planner (
    .off_i   (addr_q[1:0]),
    .len_i   (len_q),
    .we_i    (we_q),
    .wdata_i (wdata_q),
    .legal_o (legal),
    .two_o   (two),
    .s0_o    (s0),
    .s1_o    (s1)
  );

  assign cur         = step_q ? s1 : s0;
  assign bus_valid_o = (state_q == ST_ISSUE) && legal;
  assign bus_kind_o  = cur.kind;
  assign bus_addr_o  = {addr_q[AW-1:2], cur.lane};
  assign bus_wdata_o = cur.data;
  assign hs          = bus_valid_o && bus_ready_i;
  assign accept      = (state_q == ST_IDLE) && req_i;
  assign done_o      = (state_q == ST_FIN);

  nas_read_pack i_pack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (accept),
    .cap_i    (hs && !we_q),
    .second_i (step_q),
    .split_i  (two),
    .hi_i     (addr_q[1]),
    .half_i   (bus_rdata_i),
    .data_o   (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      len_q   <= '0;
      wdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          state_q <= ST_ISSUE;
          step_q  <= 1'b0;
          we_q    <= we_i;
          addr_q  <= addr_i;
          len_q   <= len_i;
          wdata_q <= wdata_i;
        end
        ST_ISSUE: begin
          if (!legal) state_q <= ST_FIN;
          else if (hs) begin
            if (step_q || !two) state_q <= ST_FIN;
            else                step_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/narrow_access_seq_chk.sv
module narrow_access_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [2:0]    len_i,
  input logic [31:0]   wdata_i,
  input logic          done_o,
  input logic [31:0]   rdata_o,
  input logic          bus_valid_o,
  input logic [1:0]    bus_kind_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [15:0]   bus_wdata_o,
  input logic          bus_ready_i,
  input logic [15:0]   bus_rdata_i
);
  // R8
  bus_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && !bus_ready_i |=> bus_valid_o && $stable(bus_addr_o)
      && $stable(bus_kind_o) && $stable(bus_wdata_o));
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && bus_valid_o));
  // R5
  byte_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && bus_kind_o == 2'd2 |-> bus_wdata_o[15:8] == 8'h00);
  // R2
  word_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && bus_kind_o != 2'd2 |-> !bus_addr_o[0]);
  // R6
  kind_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> bus_kind_o != 2'd3);
  // R10
  busy_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && bus_ready_i |=> !bus_valid_o || bus_addr_o[AW-1:2] == $past(bus_addr_o[AW-1:2]));
endmodule

bind narrow_access_seq narrow_access_seq_chk #(.AW(AW)) i_chk (.*);

// File: tb/test_narrow_access_seq.sv
module test_narrow_access_seq;
  localparam int AW = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, ready = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [2:0] len = '0;
  logic [31:0] wdata = '0;
  logic done, bvalid;
  logic [31:0] rdata;
  logic [1:0] bkind;
  logic [AW-1:0] baddr;
  logic [15:0] bwdata, brdata;
  logic [7:0] salt = 8'h00;
  int n_run = 0, n_fail = 0, cyc = 0, ready_pct = 100;
  int n_log = 0;
  logic [1:0]    lg_kind [8];
  logic [AW-1:0] lg_addr [8];
  logic [15:0]   lg_data [8];
  int            lg_cyc  [8];
  int exp_n;
  logic [1:0]    ex_kind [2];
  logic [AW-1:0] ex_addr [2];
  logic [15:0]   ex_data [2];
  logic [31:0]   ex_rdata;

  always #2 clk = ~clk;

  function automatic logic [15:0] rd_fn(input logic [AW-1:0] a, input logic [7:0] s);
    return {a[7:0] ^ 8'hC3 ^ s, a[7:0] + s};
  endfunction
  assign brdata = rd_fn(baddr, salt);

  narrow_access_seq #(.AW(AW)) i_narrow_access_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .len_i(len), .wdata_i(wdata), .done_o(done), .rdata_o(rdata),
    .bus_valid_o(bvalid), .bus_kind_o(bkind), .bus_addr_o(baddr),
    .bus_wdata_o(bwdata), .bus_ready_i(ready), .bus_rdata_i(brdata));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (bvalid && ready) begin
      lg_kind[n_log % 8] <= bkind;
      lg_addr[n_log % 8] <= baddr;
      lg_data[n_log % 8] <= bwdata;
      lg_cyc[n_log % 8]  <= cyc;
      n_log <= n_log + 1;
    end
  end

  always @(negedge clk) ready <= (($urandom % 100) < ready_pct);

  task automatic chk(input bit ok, input string r, input string what, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] k, input logic [AW-1:0] a, input logic [15:0] d);
    ex_kind[exp_n] = k; ex_addr[exp_n] = a; ex_data[exp_n] = d; exp_n++;
  endtask

  // Expected cycle list, from the requirements
  task automatic build_exp(input logic [AW-1:0] a, input logic [2:0] l, input bit w, input logic [31:0] d);
    int o;
    logic [AW-1:0] ev;
    o = int'(a[1:0]);
    ev = {a[AW-1:1], 1'b0};
    exp_n = 0; ex_rdata = '0;
    if (l == 0 || l > 3 || o + int'(l) > 4) return;
    if (!w) begin
      push(2'd0, ev, 16'h0);
      if (int'(l) + (o % 2) <= 2) begin
        if (a[1]) ex_rdata = {rd_fn(ev, salt), 16'h0};
        else      ex_rdata = {16'h0, rd_fn(ev, salt)};
      end else begin
        push(2'd0, ev + 2, 16'h0);
        ex_rdata = {rd_fn(ev + 2, salt), rd_fn(ev, salt)};
      end
    end else if (l == 1) push(2'd2, a, {8'h0, d[7:0]});
    else if (l == 2) begin
      if (a[0]) begin push(2'd2, a, {8'h0, d[7:0]}); push(2'd2, a + 1, {8'h0, d[15:8]}); end
      else push(2'd1, a, d[15:0]);
    end else begin
      if (a[0]) begin push(2'd2, a, {8'h0, d[7:0]}); push(2'd1, a + 1, d[23:8]); end
      else begin push(2'd1, a, d[15:0]); push(2'd2, a + 2, {8'h0, d[23:16]}); end
    end
  endtask

  task automatic run(input logic [AW-1:0] a, input logic [2:0] l, input bit w, input logic [31:0] d, input bit hold);
    int start, k;
    bit legal;
    salt = 8'($urandom);
    build_exp(a, l, w, d);
    legal = !(l == 0 || l > 3 || int'(a[1:0]) + int'(l) > 4);
    @(negedge clk);
    addr = a; len = l; we = w; wdata = d; req = 1'b1;
    start = n_log;
    @(negedge clk);
    if (hold) begin addr = ~a; len = 3'd3; we = ~w; wdata = ~d; end  // R10 stimulus
    else req = 1'b0;
    k = 1;
    while (!done && k < 400) begin @(negedge clk); k++; end
    req = 1'b0;
    chk(done, "R8", "done seen", done, 1);
    chk(n_log - start == exp_n, hold ? "R10" : (w ? "R6" : "R2"), "cycle count", n_log - start, exp_n);
    for (int i = 0; i < exp_n && i < n_log - start; i++) begin
      chk(lg_kind[(start + i) % 8] == ex_kind[i], w ? "R7" : "R2", "kind", lg_kind[(start + i) % 8], ex_kind[i]);
      chk(lg_addr[(start + i) % 8] == ex_addr[i], w ? "R7" : "R2", "addr", lg_addr[(start + i) % 8], ex_addr[i]);
      if (w) chk(lg_data[(start + i) % 8] == ex_data[i], l == 1 ? "R5" : "R6", "data", lg_data[(start + i) % 8], ex_data[i]);
    end
    if (!legal) begin
      chk(k == 2, "R9", "ignored done timing", k, 2);
      chk(rdata == 32'h0, "R9", "ignored rdata", rdata, 0);
    end else begin
      chk(lg_cyc[(n_log - 1) % 8] == cyc - 1, "R8", "done after last cycle", lg_cyc[(n_log - 1) % 8], cyc - 1);
      if (!w) chk(rdata == ex_rdata, exp_n == 1 ? "R3" : "R4", "rdata", rdata, ex_rdata);
    end
    @(negedge clk);
    chk(!done && !bvalid, "R8", "done one cycle", {done, bvalid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !bvalid && rdata == 0, "R1", "reset state", {done, bvalid, rdata}, 0);
    rst_n = 1'b1;
    // directed: every legal pair, both directions
    for (int o = 0; o < 4; o++)
      for (int l = 1; o + l <= 4 && l <= 3; l++) begin
        run(AW'(16'h1230 + o), 3'(l), 1'b0, 32'h00A1B2C3, 1'b0);
        run(AW'(16'h1230 + o), 3'(l), 1'b1, 32'h00A1B2C3, 1'b0);
      end
    run(16'h0040, 3'd0, 1'b0, 32'h1, 1'b0);   // R9
    run(16'h0040, 3'd4, 1'b1, 32'h1, 1'b0);   // R9
    run(16'h0041, 3'd7, 1'b0, 32'h1, 1'b0);   // R9
    run(16'h0043, 3'd2, 1'b1, 32'h1, 1'b0);   // R9 overflow
    ready_pct = 30;
    run(16'h0051, 3'd3, 1'b0, 32'h0, 1'b1);   // R10
    run(16'h0050, 3'd3, 1'b1, 32'h00112233, 1'b1);  // R10
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      logic [2:0] l;
      a = AW'($urandom);
      l = ($urandom % 10 == 0) ? 3'($urandom) : 3'(1 + $urandom % (4 - int'(a[1:0]) < 3 ? 4 - int'(a[1:0]) : 3));
      ready_pct = 20 + int'($urandom % 81);
      run(a, l, 1'($urandom), $urandom, ($urandom % 4) == 0);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule